// File: doc/BRIEF.md
# PCM Transmit Serial Port

This block serialises one companded PCM code word per frame onto a three-state serial output. Its inputs are a bit clock, a transmit frame sync, the parallel code word and a power-down level. The bit clock and the sync come from another clock domain. The block re-times both into the faster system clock and detects their edges there. Every output decision is made on those detected edges.

The block works out the framing style from the sync pulse itself. A narrow pulse selects short-frame timing and a wide pulse selects long-frame timing. The enable and disable points of the output follow the rules for the selected style. A time-slot strobe marks the bits being sent. After reset or power-down, the output stays quiet until the port has seen two frame syncs. The system clock must run at four or more times the bit-clock rate. Every bit-clock or sync edge reaches the outputs three system clocks after it arrives at the pins.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset, `sdata_oe` is 0, `slot_n` is 1 and `sdata` is 0, and the port uses short-frame timing.
- R2: Short-frame timing works as follows. When the sync is seen high at a falling bit-clock edge, the next rising edge enables the output and shows bit 7, the MSB, first. Each of the next seven rising edges shows the next lower bit. The falling edge after the eighth rising edge disables the output.
- R3: Long-frame timing applies to the frame after a sync pulse that covered three or more falling bit-clock edges. In long-frame timing the output is enabled, showing bit 7, when both the sync and the bit clock are high, whichever rose later.
- R4: In long-frame timing the output is disabled at the later of two events: the falling bit-clock edge after the eighth rising edge, or the sync going low. While the sync stays high past the word, bit 0 is held and the output stays enabled.
- R5: A sync pulse that covers one or two falling bit-clock edges selects short-frame timing for the next frame. The framing style changes only when a sync pulse ends.
- R6: Each frame start captures `code_in`. The word sent in a frame is the one captured at the previous frame start.
- R7: From the system clock after `pwr_down` is seen high, `sdata_oe` is 0.
- R8: After reset, or after `pwr_down` returns low, the frame begun by the first sync is not driven. Output resumes with the frame begun by the second sync.
- R9: `slot_n` is 0 exactly while the output is enabled and 1 otherwise.
- R10: A new frame start during a word abandons that word. In short-frame timing the output is disabled at that falling edge. Sending then restarts from bit 7 of the next word at the enabling edge.
- R11: `sdata` is 0 whenever `sdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_in | input | 1 | Bit clock, asynchronous to `clk` |
| fsync_in | input | 1 | Transmit frame sync, asynchronous to `clk` |
| pwr_down | input | 1 | Power-down level, active high, synchronous to `clk` |
| code_in | input | WORD_W | Code word to capture at each frame start |
| sdata | output | 1 | Serial data, MSB first |
| sdata_oe | output | 1 | Output enable for the three-state data pad |
| slot_n | output | 1 | Time-slot strobe, active low |

## Verification
Two pairs of events can land on the same system clock. The first pair is a new frame start and the shifting of a word still in progress. The bench provokes it by pulsing the sync halfway through a short-frame word. It then checks that the output drops at that falling edge and that the next word starts again from its MSB. The second pair is the end of the eighth bit and a long sync that is still high. The bench holds the sync well past the word and checks three things: the output stays enabled, the LSB is held, and the disable waits for the sync to fall.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_PEND  = 2'd1,
      TX_SHIFT = 2'd2,
      TX_TAIL  = 2'd3
   } tx_state_e;

   typedef enum logic {
      FRM_SHORT = 1'b0,
      FRM_LONG  = 1'b1
   } frame_mode_e;

   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } edge_ev_t;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync
   import pcm_tx_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     d_in,
   output edge_ev_t ev
);

   initial begin
      if (STAGES < 2) $fatal(1, "pcm_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;
   logic              lvl;

   assign lvl = chain_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_in};
         last_q  <= lvl;
      end
   end

   always_comb begin
      ev.lvl  = lvl;
      ev.rise = lvl & ~last_q;
      ev.fall = ~lvl & last_q;
   end

endmodule

// File: rtl/pcm_frame_mode.sv
module pcm_frame_mode
   import pcm_tx_pkg::*;
#(
   parameter int LONG_MIN = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  edge_ev_t    f_ev,
   input  edge_ev_t    b_ev,
   output frame_mode_e mode
);

   initial begin
      if (LONG_MIN < 3) $fatal(1, "pcm_frame_mode: LONG_MIN must be at least 3");
   end

   localparam int               CNT_W   = $clog2(LONG_MIN + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LONG_MIN);

   logic [CNT_W-1:0] cnt_q;
   frame_mode_e      mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mode_q <= FRM_SHORT;
      end else if (f_ev.fall) begin
         mode_q <= (cnt_q >= CNT_MAX) ? FRM_LONG : FRM_SHORT;
         cnt_q  <= '0;
      end else if (f_ev.lvl && b_ev.fall && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign mode = mode_q;

   // R5
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !f_ev.fall |=> $stable(mode_q));

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
   import pcm_tx_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  frame_mode_e       mode,
   input  edge_ev_t          f_ev,
   input  edge_ev_t          b_ev,
   input  logic [WORD_W-1:0] code_in,
   output logic              start,
   output logic              oe,
   output logic              bit_out
);

   initial begin
      if (WORD_W < 2) $fatal(1, "pcm_tx_shifter: WORD_W must be at least 2");
   end

   localparam int               IDX_W = $clog2(WORD_W);
   localparam logic [IDX_W-1:0] LAST  = IDX_W'(WORD_W - 1);

   tx_state_e         state_q;
   logic              oe_q;
   logic              seen_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WORD_W-1:0] shreg_q;
   logic [WORD_W-1:0] hold_q;
   logic              start_short;
   logic              start_long;

   assign start_short = (mode == FRM_SHORT) && b_ev.fall && f_ev.lvl && !seen_q;
   assign start_long  = (mode == FRM_LONG) && f_ev.rise;
   assign start       = start_short | start_long;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         oe_q    <= 1'b0;
         seen_q  <= 1'b0;
         idx_q   <= '0;
         shreg_q <= '0;
         hold_q  <= '0;
      end else begin
         if (!f_ev.lvl)       seen_q <= 1'b0;
         else if (start_short) seen_q <= 1'b1;

         if (start) begin
            hold_q  <= code_in;
            shreg_q <= hold_q;
            idx_q   <= '0;
            if (start_long && b_ev.lvl) begin
               state_q <= TX_SHIFT;
               oe_q    <= 1'b1;
            end else begin
               state_q <= TX_PEND;
               oe_q    <= 1'b0;
            end
         end else begin
            unique case (state_q)
               TX_PEND: begin
                  if (b_ev.rise) begin
                     state_q <= TX_SHIFT;
                     oe_q    <= 1'b1;
                  end
               end
               TX_SHIFT: begin
                  if (b_ev.rise && idx_q != LAST) begin
                     idx_q   <= idx_q + 1'b1;
                     shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                  end else if (b_ev.fall && idx_q == LAST) begin
                     if (mode == FRM_SHORT || !f_ev.lvl) begin
                        state_q <= TX_IDLE;
                        oe_q    <= 1'b0;
                     end else begin
                        state_q <= TX_TAIL;
                     end
                  end
               end
               TX_TAIL: begin
                  if (!f_ev.lvl) begin
                     state_q <= TX_IDLE;
                     oe_q    <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign oe      = oe_q;
   assign bit_out = shreg_q[WORD_W-1];

   // R2 R3
   oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> ($past(b_ev.rise) || $past(f_ev.rise)));

   // R2
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && $past(oe_q) && !$past(b_ev.rise) && !$past(f_ev.rise))
         |-> $stable(shreg_q[WORD_W-1]));

   // R4 R10
   oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_q) |-> ($past(b_ev.fall) || $past(f_ev.fall) || $past(f_ev.rise)));

endmodule

// File: rtl/pcm_tx_gate.sv
module pcm_tx_gate #(
   parameter int GATE_SYNCS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_down,
   input  logic start,
   output logic allow
);

   initial begin
      if (GATE_SYNCS < 1) $fatal(1, "pcm_tx_gate: GATE_SYNCS must be at least 1");
   end

   logic allow_q;

   generate
      if (GATE_SYNCS == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        allow_q <= 1'b0;
            else if (pwr_down) allow_q <= 1'b0;
            else if (start)    allow_q <= 1'b1;
         end
      end else begin : g_count
         localparam int               CNT_W = $clog2(GATE_SYNCS + 1);
         localparam logic [CNT_W-1:0] OPEN  = CNT_W'(GATE_SYNCS - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q   <= '0;
               allow_q <= 1'b0;
            end else if (pwr_down) begin
               cnt_q   <= '0;
               allow_q <= 1'b0;
            end else if (start && !allow_q) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == OPEN) allow_q <= 1'b1;
            end
         end
      end
   endgenerate

   assign allow = allow_q;

   // R7
   pd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> !allow_q);

   // R8
   gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(allow_q) |-> ($past(start) && !$past(pwr_down)));

endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
   import pcm_tx_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LONG_MIN    = 3,
   parameter int GATE_SYNCS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_in,
   input  logic              fsync_in,
   input  logic              pwr_down,
   input  logic [WORD_W-1:0] code_in,
   output logic              sdata,
   output logic              sdata_oe,
   output logic              slot_n
);

   edge_ev_t    b_ev;
   edge_ev_t    f_ev;
   frame_mode_e mode;
   logic        start;
   logic        oe_int;
   logic        bit_int;
   logic        allow;

   pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (bclk_in),
      .ev    (b_ev)
   );

   pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_fsync_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (fsync_in),
      .ev    (f_ev)
   );

   pcm_frame_mode #(.LONG_MIN(LONG_MIN)) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .f_ev  (f_ev),
      .b_ev  (b_ev),
      .mode  (mode)
   );

   pcm_tx_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .f_ev    (f_ev),
      .b_ev    (b_ev),
      .code_in (code_in),
      .start   (start),
      .oe      (oe_int),
      .bit_out (bit_int)
   );

   pcm_tx_gate #(.GATE_SYNCS(GATE_SYNCS)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_down (pwr_down),
      .start    (start),
      .allow    (allow)
   );

   assign sdata_oe = oe_int & allow;
   assign sdata    = sdata_oe & bit_int;
   assign slot_n   = ~sdata_oe;

   // R7
   oe_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> !sdata_oe);

   // R11
   quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_int |-> !sdata);

endmodule

// File: tb/pcm_tx_port_bench.sv
module pcm_tx_port_bench;
   localparam int W = 8;
   localparam int H = 6;
   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bclk_in = 1'b0;
   logic         fsync_in = 1'b0;
   logic         pwr_down = 1'b0;
   logic [W-1:0] code_in = '0;
   logic         sdata;
   logic         sdata_oe;
   logic         slot_n;

   int n_chk = 0;
   int n_err = 0;
   logic finished = 1'b0;

   logic fs_h [N];
   logic fs_l [N];
   logic pd_h [N];
   logic pd_l [N];
   logic d_hi [N];
   logic oe_hi [N];
   logic oe_lo [N];
   logic sl_hi [N];
   logic [W-1:0] held = '0;
   logic [W-1:0] sent;

   always #4 clk = ~clk;

   pcm_tx_port u_pcm_tx_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_in  (bclk_in),
      .fsync_in (fsync_in),
      .pwr_down (pwr_down),
      .code_in  (code_in),
      .sdata    (sdata),
      .sdata_oe (sdata_oe),
      .slot_n   (slot_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_plan();
      for (int c = 0; c < N; c++) begin
         fs_h[c] = 1'b0; fs_l[c] = 1'b0; pd_h[c] = 1'b0; pd_l[c] = 1'b0;
      end
   endtask

   task automatic sync_span(input int first, input int last);
      for (int c = first; c <= last; c++) begin
         fs_h[c] = 1'b1; fs_l[c] = 1'b1;
      end
   endtask

   task automatic run(input int n, input logic [W-1:0] code);
      code_in = code;
      sent = held;
      held = code;
      for (int c = 0; c < n; c++) begin
         bclk_in = 1'b1; fsync_in = fs_h[c]; pwr_down = pd_h[c];
         repeat (H) @(negedge clk);
         d_hi[c] = sdata; oe_hi[c] = sdata_oe; sl_hi[c] = slot_n;
         bclk_in = 1'b0; fsync_in = fs_l[c]; pwr_down = pd_l[c];
         repeat (H) @(negedge clk);
         oe_lo[c] = sdata_oe;
      end
   endtask

   task automatic check_bits(input string req, input int first, input int nbits,
                             input logic [W-1:0] w);
      for (int i = 0; i < nbits; i++)
         check(req, {29'd0, oe_hi[first+i], d_hi[first+i], sl_hi[first+i]},
               {29'd0, 1'b1, w[W-1-i], 1'b0});
   endtask

   task automatic t_reset();
      check("R1 oe after reset", sdata_oe, 0);
      check("R1 slot_n after reset", slot_n, 1);
      check("R1/R11 sdata after reset", sdata, 0);
   endtask

   task automatic t_powerup();
      logic any_oe;
      clear_plan(); fs_h[0] = 1; fs_l[0] = 1;
      run(12, 8'hA5);
      any_oe = 1'b0;
      for (int c = 0; c < 12; c++) any_oe |= oe_hi[c] | oe_lo[c];
      check("R8 first sync not driven", any_oe, 0);
      clear_plan(); fs_h[0] = 1; fs_l[0] = 1;
      run(12, 8'h3C);
      check("R2 not enabled in sync cycle", oe_hi[0], 0);
      check_bits("R2/R6/R9 short word", 1, W, sent);
      check("R2 enabled through bit 7", oe_lo[7], 1);
      check("R2 disabled after eighth bit", oe_lo[8], 0);
      check("R11 sdata quiet", d_hi[9], 0);
      check("R9 slot_n idle", sl_hi[9], 1);
   endtask

   task automatic t_short2();
      clear_plan(); sync_span(0, 1);
      run(12, 8'h5A);
      check_bits("R5 two-wide sync short", 1, W, sent);
      check("R5 two-wide disable", oe_lo[8], 0);
   endtask

   task automatic t_long();
      clear_plan(); sync_span(0, 3);
      run(12, 8'h0F);
      clear_plan(); sync_span(0, 3);
      run(12, 8'hC3);
      check_bits("R3 long enable at sync rise", 0, W, sent);
      check("R4 long disable after bit 0", oe_lo[7], 0);
   endtask

   task automatic t_long_late();
      clear_plan(); fs_l[0] = 1; sync_span(1, 3); fs_h[4] = 1;
      run(12, 8'h96);
      check("R3 waits for bclk rise", oe_lo[0], 0);
      check_bits("R3 long late enable", 1, W, sent);
      check("R4 long late disable", oe_lo[8], 0);
   endtask

   task automatic t_long_stretch();
      clear_plan(); sync_span(0, 9);
      run(14, 8'h69);
      check_bits("R4 stretched word", 0, W, sent);
      check("R4 held past word", oe_lo[7], 1);
      check("R4 LSB held", {oe_hi[8], d_hi[8]}, {1'b1, sent[0]});
      check("R4 held until sync low", oe_lo[9], 1);
      check("R4 disabled by sync low", oe_hi[10], 0);
   endtask

   task automatic t_back_short();
      clear_plan(); sync_span(0, 1);
      run(12, 8'h81);
      clear_plan(); fs_h[0] = 1; fs_l[0] = 1;
      run(12, 8'h7E);
      check("R5 back to short, not in sync cycle", oe_hi[0], 0);
      check_bits("R5 back to short word", 1, W, sent);
   endtask

   task automatic t_abort();
      logic [W-1:0] first_w;
      clear_plan(); fs_h[0] = 1; fs_l[0] = 1; fs_h[4] = 1; fs_l[4] = 1;
      run(16, 8'hE7);
      first_w = sent;
      check_bits("R10 partial word", 1, 4, first_w);
      check("R10 abort disables", oe_lo[4], 0);
      check_bits("R10 restart from MSB", 5, W, 8'hE7);
      check("R10 restart disable", oe_lo[12], 0);
   endtask

   task automatic t_powerdown();
      logic any_oe;
      clear_plan(); fs_h[0] = 1; fs_l[0] = 1;
      for (int c = 3; c < 12; c++) pd_l[c] = 1;
      for (int c = 4; c < 12; c++) pd_h[c] = 1;
      run(12, 8'h11);
      check_bits("R7 before power-down", 1, 2, sent);
      check("R7 off in power-down", oe_lo[3], 0);
      any_oe = 1'b0;
      for (int c = 4; c < 9; c++) any_oe |= oe_hi[c];
      check("R7 stays off", any_oe, 0);
      clear_plan(); fs_h[0] = 1; fs_l[0] = 1;
      run(12, 8'h22);
      any_oe = 1'b0;
      for (int c = 0; c < 12; c++) any_oe |= oe_hi[c] | oe_lo[c];
      check("R8 first sync after release", any_oe, 0);
      clear_plan(); fs_h[0] = 1; fs_l[0] = 1;
      run(12, 8'h33);
      check_bits("R8/R6 second sync after release", 1, W, sent);
   endtask

   initial begin
      clear_plan();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_powerup();
      t_short2();
      t_long();
      t_long_late();
      t_long_stretch();
      t_back_short();
      t_abort();
      t_powerdown();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule